// File: doc/BRIEF.md
# Early-Grant Channel Arbiter

This block picks which of several requesters may drive a shared four-phase bus channel next. Every requester has its own request line and gets its own grant line back. A grant is an early grant. It gives permission to start the next cycle once the channel has returned to idle, so the arbiter can choose the next owner while the current owner's cycle is still completing.

The requester that holds the grant keeps it for as long as its request stays high. A requester that needs several back-to-back cycles as one atomic sequence keeps its request raised and so keeps the channel. When the owner lowers its request, which it does after the acknowledge of its last cycle has risen, the grant is withdrawn. On a later clock edge the next owner is chosen by rotating priority, beginning with the index just after the previous owner.

The block is clocked logic. The channel's request and acknowledge levels arrive asynchronously and pass through a synchronizer before the arbiter uses them. Requester lines are assumed to come from interfaces clocked by the same clock. The arbiter uses the synchronized channel levels for one thing only: it holds back a fresh grant while a cycle is still in its push phase (channel request high, acknowledge low).

Top module: `chan_arb_early_grant`

## Requirements
- R1: At most one bit of `grantOut` is high in any cycle.
- R2: While `rstN` is low, every grant is cleared at once, without waiting for a clock edge, and the rotation restarts as though index NUM_REQ-1 had been the previous owner.
- R3: A grant is only given to a requester whose request was high on the edge that issued it. A requester may start a channel cycle only while it holds the grant.
- R4: While the owner's request stays high, its grant stays high on every edge. This holds across any number of channel cycles and whatever other requesters are doing.
- R5: The grant is removed on the first clock edge at which the owner's request is sampled low.
- R6: The grant never moves directly from one requester to another. There is at least one edge with no grant between two owners.
- R7: From the no-grant state, the next grant goes to the first raised request found when searching from the previous owner's index plus one, wrapping from NUM_REQ-1 to 0. Straight after reset, index 0 is searched first.
- R8: No new grant is issued while the synchronized channel levels show a push phase (request high, acknowledge low). The channel levels pass through SYNC_STAGES flops, so a change on the channel is seen SYNC_STAGES edges later and acted on at the edge after that.
- R9: When all NUM_REQ requesters ask continuously and each releases after one cycle, every run of NUM_REQ consecutive grants contains each requester exactly once.
- R10: A new grant may be issued while the previous cycle's acknowledge is still high, so arbitration overlaps the return-to-zero phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | NUM_REQ | Per-requester request lines |
| chanReq | input | 1 | Channel request level (asynchronous) |
| chanAck | input | 1 | Channel acknowledge level (asynchronous) |
| grantOut | output | NUM_REQ | Per-requester early grant lines, one-hot or zero |

## Verification
The bench builds the arbiter with NUM_REQ = 5 and SYNC_STAGES = 2. Five requesters is not a power of two, so the rotating search has to wrap past index codes that belong to no requester, and a search that starts from the last index is exercised. With two synchronizer stages the push-phase hold lasts a known number of edges, so the bench can check the exact edge at which a blocked grant is finally released. The bench also checks that the next owner is granted while the old acknowledge is still high.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;

  typedef enum logic [0:0] {
    ARB_IDLE  = 1'b0,
    ARB_OWNED = 1'b1
  } arbState_t;

  // Strobes from the control FSM to the grant datapath
  typedef struct packed {
    logic issue;   // load the picked requester as new owner
    logic drop;    // clear the grant and remember the owner
  } arbStrobe_t;

endpackage

// File: rtl/chan_arb_sync.sv
module chan_arb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dOut = dIn;
    end else begin : g_chain
      logic [WIDTH-1:0] stageQ [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) stageQ[s] <= '0;
            else       stageQ[s] <= dIn;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) stageQ[s] <= '0;
            else       stageQ[s] <= stageQ[s-1];
          end
        end
      end
      assign dOut = stageQ[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/chan_arb_ctrl.sv
module chan_arb_ctrl
  import chan_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       ownerReq,
  input  logic       chanReqSync,
  input  logic       chanAckSync,
  output arbStrobe_t strobe
);

  arbState_t stateQ, stateD;
  logic      pushPhase;

  assign pushPhase = chanReqSync & ~chanAckSync;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    unique case (stateQ)
      ARB_IDLE: begin
        // no owner: hand out the next grant unless a cycle is being pushed
        if (anyReq && !pushPhase) begin
          strobe.issue = 1'b1;
          stateD       = ARB_OWNED;
        end
      end
      ARB_OWNED: begin
        // a held request locks the channel; its fall ends ownership
        if (!ownerReq) begin
          strobe.drop = 1'b1;
          stateD      = ARB_IDLE;
        end
      end
      default: stateD = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ARB_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/chan_arb_dp.sv
module chan_arb_dp
  import chan_arb_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqIn,
  input  arbStrobe_t         strobe,
  output logic [NUM_REQ-1:0] grantOut,
  output logic               anyReq,
  output logic               ownerReq
);

  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);
  localparam logic [IDX_W:0]   REQ_CNT  = (IDX_W+1)'(NUM_REQ);

  logic [IDX_W-1:0] ownerIdx;
  logic [IDX_W-1:0] prevOwner;
  logic [IDX_W-1:0] pickIdx;
  logic [IDX_W:0]   pickSum;
  logic             pickFound;
  logic [NUM_REQ-1:0] grantQ;

  assign anyReq   = |reqIn;
  assign ownerReq = reqIn[ownerIdx];
  assign grantOut = grantQ;

  // rotating search that starts one past the previous owner
  always_comb begin
    pickIdx   = prevOwner;
    pickFound = 1'b0;
    pickSum   = '0;
    for (int off = 1; off <= NUM_REQ; off++) begin
      pickSum = {1'b0, prevOwner} + (IDX_W+1)'(off);
      if (pickSum >= REQ_CNT) pickSum = pickSum - REQ_CNT;
      if (!pickFound && reqIn[IDX_W'(pickSum)]) begin
        pickIdx   = IDX_W'(pickSum);
        pickFound = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerIdx  <= LAST_IDX;
      prevOwner <= LAST_IDX;
    end else if (strobe.issue) begin
      ownerIdx  <= pickIdx;
    end else if (strobe.drop) begin
      prevOwner <= ownerIdx;
    end
  end

  // one flop per requester lane
  generate
    for (genvar lane = 0; lane < NUM_REQ; lane++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          grantQ[lane] <= 1'b0;
        else if (strobe.issue)
          grantQ[lane] <= (pickIdx == IDX_W'(lane));
        else if (strobe.drop)
          grantQ[lane] <= 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/chan_arb_early_grant.sv
module chan_arb_early_grant
  import chan_arb_pkg::*;
#(
  parameter int NUM_REQ     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqIn,
  input  logic               chanReq,
  input  logic               chanAck,
  output logic [NUM_REQ-1:0] grantOut
);

  logic [1:0] chanLvlSync;
  logic       anyReq;
  logic       ownerReq;
  arbStrobe_t strobe;

  chan_arb_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) uSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({chanReq, chanAck}),
    .dOut (chanLvlSync)
  );

  chan_arb_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .anyReq      (anyReq),
    .ownerReq    (ownerReq),
    .chanReqSync (chanLvlSync[1]),
    .chanAckSync (chanLvlSync[0]),
    .strobe      (strobe)
  );

  chan_arb_dp #(
    .NUM_REQ (NUM_REQ)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .strobe   (strobe),
    .grantOut (grantOut),
    .anyReq   (anyReq),
    .ownerReq (ownerReq)
  );

endmodule

// File: rtl/chan_arb_early_grant_chk.sv
module chan_arb_early_grant_chk #(
  parameter int NUM_REQ = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqIn,
  input logic [NUM_REQ-1:0] grantOut
);

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut));

  p_reset_clear_r2: assert property (@(posedge clk)
    !rstN |-> (grantOut == '0));

  p_grant_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((grantOut != '0) && ($past(grantOut) == '0)) |-> ((grantOut & $past(reqIn)) != '0));

  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((grantOut & reqIn) != '0) |=> (grantOut == $past(grantOut)));

  p_withdraw_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((grantOut != '0) && ((grantOut & reqIn) == '0)) |=> (grantOut == '0));

  p_no_switch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut != '0) |=> ((grantOut == '0) || (grantOut == $past(grantOut))));

endmodule

bind chan_arb_early_grant chan_arb_early_grant_chk #(.NUM_REQ(NUM_REQ)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqIn    (reqIn),
  .grantOut (grantOut)
);

// File: tb/chan_arb_early_grant_test.sv
`timescale 1ns/1ps
module chan_arb_early_grant_test;

  localparam int N = 5;
  localparam int S = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqIn = '0;
  logic         chanReq = 1'b0;
  logic         chanAck = 1'b0;
  logic [N-1:0] grantOut;

  int nTests = 0;
  int nFail  = 0;
  bit modelOn = 1'b0;
  bit logOn   = 1'b0;
  int grantLog [64];
  int nLog = 0;
  logic [N-1:0] prevG = '0;

  always #2 clk = ~clk;

  chan_arb_early_grant #(.NUM_REQ(N), .SYNC_STAGES(S)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .chanReq  (chanReq),
    .chanAck  (chanAck),
    .grantOut (grantOut)
  );

  function automatic int rrPick(int last, logic [N-1:0] m);
    for (int k = 1; k <= N; k++) begin
      int j = (last + k) % N;
      if (m[j]) return j;
    end
    return -1;
  endfunction

  function automatic int idxOf(logic [N-1:0] g);
    for (int k = 0; k < N; k++) if (g[k]) return k;
    return -1;
  endfunction

  task automatic check(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  // reference model built from the requirements
  logic [N-1:0] mGrant;
  int           mLast;
  logic [S-1:0] mReqSync, mAckSync;
  logic         mPush;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mGrant   <= '0;
      mLast    <= N - 1;
      mReqSync <= '0;
      mAckSync <= '0;
    end else begin
      mReqSync <= {mReqSync[S-2:0], chanReq};
      mAckSync <= {mAckSync[S-2:0], chanAck};
      mPush = mReqSync[S-1] & ~mAckSync[S-1];
      if (mGrant != '0) begin
        if ((mGrant & reqIn) == '0) begin
          mGrant <= '0;
          mLast  <= idxOf(mGrant);
        end
      end else if (reqIn != '0 && !mPush) begin
        mGrant <= N'(1) << rrPick(mLast, reqIn);
      end
    end
  end

  // every-cycle comparison plus the grant log for fairness
  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check(grantOut == mGrant, "R4 R5 R6 R7 R8 per-cycle model", grantOut, mGrant);
      check($onehot0(grantOut), "R1 one-hot grant", grantOut, mGrant);
    end
    if (logOn && grantOut != '0 && prevG == '0 && nLog < 64) begin
      grantLog[nLog] = idxOf(grantOut);
      nLog++;
    end
    prevG = grantOut;
  end

  // one channel cycle by the owner; returns at the negedge after ack falls
  task automatic chanCycle(int owner, bit dropAfter);
    check(grantOut[owner] == 1'b1, "R3 cycle starts only with grant", grantOut, N'(1) << owner);
    chanReq = 1'b1;
    @(negedge clk); chanAck = 1'b1;
    @(negedge clk); chanReq = 1'b0;
    if (dropAfter) reqIn[owner] = 1'b0;
    @(negedge clk); chanAck = 1'b0;
  endtask

  task automatic waitGrant();
    for (int t = 0; t < 20 && grantOut == '0; t++) @(negedge clk);
  endtask

  initial begin
    #600000;
    nFail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(grantOut == '0, "R2 grants clear in reset", grantOut, '0);
    rstN = 1'b1;
    modelOn = 1'b1;
    @(negedge clk);
    check(grantOut == '0, "R3 no request gives no grant", grantOut, '0);

    // first pick after reset and lock across cycles
    reqIn = '1;
    @(negedge clk);
    check(grantOut == 5'b00001, "R7 index 0 first after reset", grantOut, 5'b00001);
    repeat (3) begin
      chanCycle(0, 1'b0);
      @(negedge clk);
    end
    check(grantOut == 5'b00001, "R4 lock held over cycles", grantOut, 5'b00001);
    reqIn[0] = 1'b0;
    @(negedge clk);
    check(grantOut == '0, "R5 withdraw after request falls", grantOut, '0);
    @(negedge clk);
    check(grantOut == 5'b00010, "R6 gap then next owner", grantOut, 5'b00010);
    reqIn = '0;
    repeat (3) @(negedge clk);

    // continuous contention
    reqIn = '1;
    nLog  = 0;
    logOn = 1'b1;
    repeat (15) begin
      int owner;
      waitGrant();
      owner = idxOf(grantOut);
      if (owner < 0) owner = 0;
      chanCycle(owner, 1'b1);
      reqIn[owner] = 1'b1;
    end
    logOn = 1'b0;
    check(grantLog[0] == 2, "R7 rotation resumes after index 1", N'(grantLog[0]), N'(2));
    for (int w = 0; w + N <= nLog; w++) begin
      logic [N-1:0] seen = '0;
      for (int k = 0; k < N; k++) seen[grantLog[w+k]] = 1'b1;
      check(seen == '1, "R9 each requester once per window", seen, '1);
    end
    check(nLog >= 10, "R9 enough grants logged", N'(nLog), N'(10));
    reqIn = '0;
    repeat (4) @(negedge clk);

    // hidden arbitration during acknowledge phase
    reqIn = 5'b00100;
    waitGrant();
    chanReq = 1'b1;
    @(negedge clk); chanAck = 1'b1;
    @(negedge clk); chanReq = 1'b0; reqIn = 5'b01000;
    @(negedge clk);
    check(grantOut == '0, "R10 old grant removed", grantOut, '0);
    @(negedge clk);
    check(grantOut == 5'b01000 && chanAck, "R10 new grant while ack high", grantOut, 5'b01000);
    chanAck = 1'b0;
    @(negedge clk);
    reqIn = '0;
    repeat (3) @(negedge clk);

    // push phase blocks new grants
    chanReq = 1'b1;
    chanAck = 1'b0;
    repeat (3) @(negedge clk);
    reqIn = 5'b00010;
    repeat (5) @(negedge clk);
    check(grantOut == '0, "R8 held during push phase", grantOut, '0);
    chanAck = 1'b1;
    @(negedge clk);
    check(grantOut == '0, "R8 sync stage 1", grantOut, '0);
    @(negedge clk);
    check(grantOut == '0, "R8 sync stage 2", grantOut, '0);
    @(negedge clk);
    check(grantOut == 5'b00010, "R8 grant after sync latency", grantOut, 5'b00010);
    chanReq = 1'b0;
    chanAck = 1'b0;
    reqIn = '0;
    repeat (3) @(negedge clk);

    // asynchronous reset while a grant is held
    reqIn = 5'b10000;
    repeat (2) @(negedge clk);
    check(grantOut == 5'b10000, "R3 grant before reset", grantOut, 5'b10000);
    #1 rstN = 1'b0;
    #0.5;
    check(grantOut == '0, "R2 asynchronous clear", grantOut, '0);
    reqIn = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    reqIn = 5'b11000;
    @(negedge clk);
    check(grantOut == 5'b01000, "R2 rotation restarts at index 0", grantOut, 5'b01000);
    reqIn = '0;
    repeat (2) @(negedge clk);

    // random requests checked by the model
    repeat (3000) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (!reqIn[i]) begin
          if ($urandom_range(3) == 0) reqIn[i] = 1'b1;
        end else if (grantOut[i] && $urandom_range(2) == 0) begin
          reqIn[i] = 1'b0;
        end
      end
    end
    reqIn = '0;
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule